// File: doc/BRIEF.md
# Eight-Function Parametric ALU

A purely combinational arithmetic and logic unit. It takes two operands of a configurable width and a 3-bit function code. It returns a result of the same width, a carry/borrow flag and a zero flag.

Four codes select arithmetic work: a sum, a difference, an increment of either operand. The other four select bitwise work: AND, OR, XOR, and inversion of the first operand. Arithmetic results wrap modulo 2^W. The carry flag reports the carry out of a sum or increment, or the borrow of a difference. The zero flag marks a result whose bits are all zero.

The block has no clock and no state. It is meant to sit inside a datapath stage whose registers belong to the surrounding design.

Top module: `alu_core`

## Requirements
- R1: Operand and result width is the parameter W. Every arithmetic result is taken modulo 2^W.
- R2: Function code 3'b000 gives a + b. carry_o is bit W of the full sum.
- R3: Function code 3'b001 gives a - b modulo 2^W. carry_o is 1 exactly when a < b as unsigned numbers (borrow).
- R4: Function code 3'b010 gives a + 1. carry_o is 1 exactly when a is all ones. Operand b has no effect.
- R5: Function code 3'b011 gives b + 1. carry_o is 1 exactly when b is all ones. Operand a has no effect.
- R6: Function code 3'b100 gives a AND b. Function code 3'b101 gives a OR b. carry_o is 0 for both.
- R7: Function code 3'b110 gives a XOR b, with carry_o 0.
- R8: Function code 3'b111 gives NOT a, with carry_o 0. Operand b has no effect.
- R9: zero_o is 1 exactly when all W result bits are 0, for every function code.
- R10: All outputs depend only on the present inputs. No clock and no stored state are involved, and every output is defined for every function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | W | First operand |
| op_b_i | input | W | Second operand |
| func_i | input | 3 | Function code |
| result_o | output | W | Result, modulo 2^W |
| carry_o | output | 1 | Carry of sum or increment, borrow of difference, 0 for bitwise codes |
| zero_o | output | 1 | Result is all zeros |

## Verification
Every function code is applied at widths 8 and 13, using a set of corner operand pairs and then random operands.

- **Sums and increments:** pairs of all ones with zero or one separate the carry cases. Zero with zero exposes a missing carry-in.
- **Differences:** equal operands, and a smaller operand minus a larger one, separate borrow from no borrow and exercise the zero flag.
- **Ignored operands:** for inversion and the two increments, the ignored operand is changed while the used one is held. The result must not move.
- **Random operands:** these catch swapped or mis-decoded bitwise functions that corner values alone can mask.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_INCA = 3'b010,
    FN_INCB = 3'b011,
    FN_AND  = 3'b100,
    FN_OR   = 3'b101,
    FN_XOR  = 3'b110,
    FN_NOTA = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu_arith.sv
// Shared adder for sum, difference and both increments.
module alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o
);
  logic [W-1:0] x_op, y_op;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    x_op = (sel_i == 2'b11) ? b_i : a_i;
    case (sel_i)
      2'b00:   y_op = b_i;
      2'b01:   y_op = ~b_i;
      default: y_op = '0;
    endcase
    cin  = |sel_i;
    full = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, cin};
    sum_o = full[W-1:0];
    // subtraction: carry out of a + ~b + 1 is the inverse of borrow
    cy_o  = (sel_i == 2'b01) ? ~full[W] : full[W];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (sel_i)
        2'b00:   res_o[i] = a_i[i] & b_i[i];
        2'b01:   res_o[i] = a_i[i] | b_i[i];
        2'b10:   res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  output logic         zero_o
);
  assign zero_o = ~|res_i;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic [2:0]   func_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o
);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] ar_res, lg_res;
  logic         ar_cy;

  alu_arith #(.W(W)) u_arith (
    .a_i(op_a_i), .b_i(op_b_i), .sel_i(func_i[1:0]),
    .sum_o(ar_res), .cy_o(ar_cy)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(op_a_i), .b_i(op_b_i), .sel_i(func_i[1:0]), .res_o(lg_res)
  );

  always_comb begin
    if (func_i[2]) begin
      result_o = lg_res;
      carry_o  = 1'b0;
    end else begin
      result_o = ar_res;
      carry_o  = ar_cy;
    end
  end

  alu_flags #(.W(W)) u_flags (.res_i(result_o), .zero_o(zero_o));

  always_comb begin
    if (alu_fn_e'(func_i) == FN_ADD)
      AST_ADD_SUM: assert ({carry_o, result_o} == {1'b0, op_a_i} + {1'b0, op_b_i}); // R2
    if (alu_fn_e'(func_i) == FN_SUB)
      AST_SUB_BORROW: assert (carry_o == (op_a_i < op_b_i)); // R3
    if (alu_fn_e'(func_i) == FN_INCA)
      AST_INCA_CARRY: assert (carry_o == (op_a_i == ONES)); // R4
    if (alu_fn_e'(func_i) == FN_INCB)
      AST_INCB_CARRY: assert (carry_o == (op_b_i == ONES)); // R5
    if (alu_fn_e'(func_i) == FN_NOTA)
      AST_NOTA_INV: assert ((result_o ^ op_a_i) == ONES); // R8
    if (zero_o)
      AST_ZERO_FLAG: assert (result_o == '0); // R9
  end
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
  localparam int WA = 8;
  localparam int WB = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [WA-1:0] a8, b8, r8;
  logic [WB-1:0] a13, b13, r13;
  logic [2:0]    fn;
  logic          c8, z8, c13, z13;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu_core #(.W(WA)) uut (
    .op_a_i(a8), .op_b_i(b8), .func_i(fn),
    .result_o(r8), .carry_o(c8), .zero_o(z8)
  );
  alu_core #(.W(WB)) uut_w (
    .op_a_i(a13), .op_b_i(b13), .func_i(fn),
    .result_o(r13), .carry_o(c13), .zero_o(z13)
  );

  function automatic string tag_of(int f);
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference model on 64-bit integers
  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input int f, output longint unsigned r, output bit c);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned s;
    c = 1'b0;
    case (f)
      0: begin s = a + b; c = s[w]; end
      1: begin s = a - b; c = (a < b); end
      2: begin s = a + 1; c = s[w]; end
      3: begin s = b + 1; c = s[w]; end
      4: s = a & b;
      5: s = a | b;
      6: s = a ^ b;
      default: s = ~a;
    endcase
    r = s & m;
  endtask

  task automatic check(input string tag, input string what,
                       input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s fn=%0d actual=%0h expected=%0h", tag, what, fn, got, exp);
    end
  endtask

  task automatic run(input longint unsigned a, input longint unsigned b, input int f);
    longint unsigned er;
    bit ec;
    @(negedge clk);
    a8 = a[WA-1:0]; b8 = b[WA-1:0];
    a13 = a[WB-1:0]; b13 = b[WB-1:0];
    fn = f[2:0];
    @(posedge clk);
    #1;
    model(WA, a & 64'hFF, b & 64'hFF, f, er, ec);
    check(tag_of(f), "w8 result (R1)", r8, er);
    check(tag_of(f), "w8 carry", c8, ec);
    check("R9", "w8 zero", z8, er == 0);
    model(WB, a & 64'h1FFF, b & 64'h1FFF, f, er, ec);
    check(tag_of(f), "w13 result (R1)", r13, er);
    check(tag_of(f), "w13 carry", c13, ec);
    check("R9", "w13 zero", z13, er == 0);
  endtask

  // ignored operand: hold the used one, change the other, output must not move
  task automatic ignore_chk(input int f, input string tag, input bit vary_b);
    logic [WB-1:0] r1;
    logic c1;
    run(64'h0A5C, 64'h1234, f);
    r1 = r13; c1 = c13;
    if (vary_b) run(64'h0A5C, 64'h1ED7, f);
    else        run(64'h17E1, 64'h1234, f);
    check(tag, "ignored operand result", r13, r1);
    check(tag, "ignored operand carry", c13, c1);
  endtask

  initial begin
    a8 = '0; b8 = '0; a13 = '0; b13 = '0; fn = 3'b000;
    #2;
    // R10: combinational with no reset; settled outputs right away
    check("R10", "initial result", r8, 0);
    check("R10", "initial carry", c8, 0);
    check("R9", "initial zero", z8, 1);
    for (int f = 0; f < 8; f++) begin
      run(0, 0, f);
      run(64'hFFFF, 64'hFFFF, f);
      run(64'hFFFF, 0, f);
      run(0, 64'hFFFF, f);
      run(1, 64'hFFFF, f);
      run(64'hFFFF, 1, f);
      run(64'h55, 64'h55, f);
      run(3, 7, f);
      for (int k = 0; k < 40; k++) run($urandom, $urandom, f);
    end
    ignore_chk(7, "R8", 1'b1);
    ignore_chk(2, "R4", 1'b1);
    ignore_chk(3, "R5", 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule